// File: doc/BRIEF.md
# Flag-Mask Branch Condition Evaluator

This block decides whether a conditional relative branch is taken. It looks at four status flags (sign, carry, zero and overflow) and a mask field from the branch opcode. A sequencer raises an evaluate strobe in the cycle it needs the answer. One cycle later the block returns a registered take decision together with a one-cycle valid pulse. The sequencer uses that decision to pick between the longer bus sequence of a taken branch and the shorter sequence of an untaken one. Fetching the displacement and updating the program counter are handled elsewhere.

Three evaluation modes are available, and a fourth encoding is reserved. The any-set mode takes a 3-bit mask and branches when at least one selected flag is set. The all-clear mode takes a 4-bit mask and branches only when every selected flag is clear. These two modes use opposite logic, so an empty mask means "never" in the first and "always" in the second. The third mode ignores the mask and the flags, and branches when an external input reports that the lower octal digit of a register index is not 7. When the sign flag is set, the result is treated as positive.

Top module: `brcond_eval`

## Requirements
- R1: While reset is high, and on the first clock edge after it, valid_o is 0 and take_o is 0.
- R2: valid_o is 1 in the cycle after a clock edge at which eval_i was 1, and 0 after every edge at which eval_i was 0.
- R3: Any-set mode (mode_i = 2'b00) takes the branch when (mask_i[0] and sign) or (mask_i[1] and carry) or (mask_i[2] and zero) holds, using the inputs sampled at the evaluate edge.
- R4: In any-set mode, mask_i[2:0] = 0 never takes the branch, and mask_i[3] has no effect.
- R5: All-clear mode (mode_i = 2'b01) takes the branch only when none of the selected flags is set. mask_i[0] selects sign, mask_i[1] carry, mask_i[2] zero and mask_i[3] overflow.
- R6: In all-clear mode, mask_i = 0 always takes the branch, whatever the flags are.
- R7: Octal mode (mode_i = 2'b10) takes the branch when oct7_i is 0 and not when it is 1. The mask and the flags have no effect in this mode.
- R8: The reserved mode (mode_i = 2'b11) never takes the branch.
- R9: After any edge at which eval_i is 0, take_o keeps its previous value, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate strobe; the inputs are sampled at this edge |
| mode_i | input | 2 | 00 any-set, 01 all-clear, 10 octal, 11 reserved |
| mask_i | input | 4 | Flag select mask from the opcode |
| flag_sign_i | input | 1 | Sign flag (set means positive) |
| flag_carry_i | input | 1 | Carry flag |
| flag_zero_i | input | 1 | Zero flag |
| flag_ovf_i | input | 1 | Overflow flag |
| oct7_i | input | 1 | High when the lower octal index digit equals 7 |
| take_o | output | 1 | Registered branch decision |
| valid_o | output | 1 | One-cycle pulse marking a fresh decision |

## Verification
The assertions check on every cycle the one-cycle timing of the valid pulse, that take_o holds between evaluations, and the fixed outcomes: an empty mask in each of the two flag modes, the inverted octal input, and the reserved encoding. The full truth table of the two mask modes, with every mix of selected flags, is covered only by the bench. The bench drives random masks and flag patterns plus directed corner cases, and compares each decision with a model written from the requirements.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    localparam int unsigned NUM_FLAGS   = 4;
    localparam int unsigned ANY_MASK_W  = 3;
    localparam int unsigned ALL_MASK_W  = NUM_FLAGS;
    localparam int unsigned MODE_W      = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_ANY_SET   = 2'b00,
        MODE_ALL_CLEAR = 2'b01,
        MODE_OCTAL     = 2'b10,
        MODE_RESERVED  = 2'b11
    } br_mode_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
        logic sign;
    } br_flags_t;

    typedef struct packed {
        br_mode_e               mode;
        logic [ALL_MASK_W-1:0]  mask;
        br_flags_t              flags;
        logic                   oct7;
    } br_req_t;

    // Bit i of the vector lines up with mask bit i.
    function automatic logic [NUM_FLAGS-1:0] flag_vec(input br_flags_t f);
        return {f.ovf, f.zero, f.carry, f.sign};
    endfunction

endpackage

// File: rtl/brc_mask_eval.sv
module brc_mask_eval #(
    parameter int unsigned W         = 3,
    parameter bit          ALL_CLEAR = 1'b0
) (
    input  logic [W-1:0] mask,
    input  logic [W-1:0] flags,
    output logic         take
);
    logic [W-1:0] hit;

    assign hit = mask & flags;

    generate
        if (ALL_CLEAR) begin : g_all_clear
            assign take = ~|hit;
        end else begin : g_any_set
            assign take = |hit;
        end
    endgenerate
endmodule

// File: rtl/brc_mode_mux.sv
module brc_mode_mux
    import brcond_pkg::*;
(
    input  br_mode_e mode,
    input  logic     any_take,
    input  logic     all_take,
    input  logic     oct7,
    output logic     take
);
    always_comb begin
        unique case (mode)
            MODE_ANY_SET:   take = any_take;
            MODE_ALL_CLEAR: take = all_take;
            MODE_OCTAL:     take = ~oct7;
            default:        take = 1'b0;
        endcase
    end
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
    import brcond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [ALL_MASK_W-1:0] mask_i,
    input  logic              flag_sign_i,
    input  logic              flag_carry_i,
    input  logic              flag_zero_i,
    input  logic              flag_ovf_i,
    input  logic              oct7_i,
    output logic              take_o,
    output logic              valid_o
);
    br_req_t              req;
    logic [NUM_FLAGS-1:0] fv;
    logic                 any_take;
    logic                 all_take;
    logic                 take_next;

    always_comb begin
        req.mode        = br_mode_e'(mode_i);
        req.mask        = mask_i;
        req.flags.sign  = flag_sign_i;
        req.flags.carry = flag_carry_i;
        req.flags.zero  = flag_zero_i;
        req.flags.ovf   = flag_ovf_i;
        req.oct7        = oct7_i;
    end

    assign fv = flag_vec(req.flags);

    brc_mask_eval #(.W(ANY_MASK_W), .ALL_CLEAR(1'b0)) u_any (
        .mask  (req.mask[ANY_MASK_W-1:0]),
        .flags (fv[ANY_MASK_W-1:0]),
        .take  (any_take)
    );

    brc_mask_eval #(.W(ALL_MASK_W), .ALL_CLEAR(1'b1)) u_all (
        .mask  (req.mask),
        .flags (fv[ALL_MASK_W-1:0]),
        .take  (all_take)
    );

    brc_mode_mux u_mux (
        .mode     (req.mode),
        .any_take (any_take),
        .all_take (all_take),
        .oct7     (req.oct7),
        .take     (take_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o  <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= eval_i;
            if (eval_i) take_o <= take_next;
        end
    end
endmodule

// File: rtl/brcond_eval_chk.sv
module brcond_eval_chk
    import brcond_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              eval_i,
    input logic [MODE_W-1:0] mode_i,
    input logic [ALL_MASK_W-1:0] mask_i,
    input logic              oct7_i,
    input logic              take_o,
    input logic              valid_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid_o && !take_o));

    a_r2_valid_after_eval: assert property (@(posedge clk) disable iff (rst)
        eval_i |=> valid_o);

    a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !eval_i |=> !valid_o);

    a_r4_any_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (eval_i && mode_i == MODE_ANY_SET && mask_i[ANY_MASK_W-1:0] == '0) |=> !take_o);

    a_r6_all_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (eval_i && mode_i == MODE_ALL_CLEAR && mask_i == '0) |=> take_o);

    a_r7_octal_inverted: assert property (@(posedge clk) disable iff (rst)
        (eval_i && mode_i == MODE_OCTAL) |=> (take_o == !$past(oct7_i)));

    a_r8_reserved_never: assert property (@(posedge clk) disable iff (rst)
        (eval_i && mode_i == MODE_RESERVED) |=> !take_o);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !eval_i |=> $stable(take_o));
endmodule

bind brcond_eval brcond_eval_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .eval_i  (eval_i),
    .mode_i  (mode_i),
    .mask_i  (mask_i),
    .oct7_i  (oct7_i),
    .take_o  (take_o),
    .valid_o (valid_o)
);

// File: tb/tb_brcond_eval.sv
module tb_brcond_eval;
    logic       clk = 1'b0;
    logic       rst;
    logic       eval_i;
    logic [1:0] mode_i;
    logic [3:0] mask_i;
    logic       fs, fc, fz, fo, oct7_i;
    logic       take_o, valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic last_take;

    always #5 clk = ~clk;

    brcond_eval dut (
        .clk(clk), .rst(rst), .eval_i(eval_i), .mode_i(mode_i), .mask_i(mask_i),
        .flag_sign_i(fs), .flag_carry_i(fc), .flag_zero_i(fz), .flag_ovf_i(fo),
        .oct7_i(oct7_i), .take_o(take_o), .valid_o(valid_o)
    );

    function automatic logic model(input logic [1:0] m, input logic [3:0] k,
                                   input logic s, input logic c, input logic z,
                                   input logic o, input logic oc);
        logic t;
        case (m)
            2'd0: t = (k[0] && s) || (k[1] && c) || (k[2] && z);
            2'd1: t = !((k[0] && s) || (k[1] && c) || (k[2] && z) || (k[3] && o));
            2'd2: t = !oc;
            default: t = 1'b0;
        endcase
        return t;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [3:0] k, input logic [3:0] f,
                         input logic oc, input logic ev);
        mode_i = m; mask_i = k; fs = f[0]; fc = f[1]; fz = f[2]; fo = f[3];
        oct7_i = oc; eval_i = ev;
    endtask

    // Drive at negedge, register at posedge, sample at the next negedge.
    task automatic do_eval(input string req, input logic [1:0] m, input logic [3:0] k,
                           input logic [3:0] f, input logic oc);
        logic e;
        e = model(m, k, f[0], f[1], f[2], f[3], oc);
        drive(m, k, f, oc, 1'b1);
        @(negedge clk);
        check({req, " valid"}, valid_o, 1'b1);
        check(req, take_o, e);
        last_take = e;
    endtask

    task automatic do_idle(input logic [1:0] m, input logic [3:0] k,
                           input logic [3:0] f, input logic oc);
        drive(m, k, f, oc, 1'b0);
        @(negedge clk);
        check("R2 idle valid", valid_o, 1'b0);
        check("R9 hold", take_o, last_take);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        drive(2'd1, 4'd0, 4'hF, 1'b0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check("R1 reset valid", valid_o, 1'b0);
        check("R1 reset take", take_o, 1'b0);
        rst = 1'b0;
        last_take = 1'b0;
        drive(2'd0, 4'd0, 4'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 idle after reset", valid_o, 1'b0);

        // Directed corner cases
        do_eval("R3 sign selected", 2'd0, 4'b0001, 4'b0001, 1'b0);
        do_eval("R3 carry not selected", 2'd0, 4'b0101, 4'b0010, 1'b0);
        do_eval("R3 zero selected", 2'd0, 4'b0100, 4'b0100, 1'b1);
        do_eval("R4 any empty mask", 2'd0, 4'b0000, 4'b1111, 1'b0);
        do_eval("R4 any mask bit3 ignored", 2'd0, 4'b1000, 4'b1111, 1'b0);
        do_idle(2'd1, 4'd0, 4'd0, 1'b0);
        do_eval("R6 all empty mask", 2'd1, 4'b0000, 4'b1111, 1'b1);
        do_eval("R5 overflow set blocks", 2'd1, 4'b1000, 4'b1000, 1'b0);
        do_eval("R5 selected clear", 2'd1, 4'b0110, 4'b1001, 1'b0);
        do_idle(2'd0, 4'b0001, 4'b0001, 1'b0);
        do_eval("R7 octal low", 2'd2, 4'b0000, 4'b0000, 1'b0);
        do_eval("R7 octal high", 2'd2, 4'b1111, 4'b0000, 1'b1);
        do_eval("R7 octal mask ignored", 2'd2, 4'b0111, 4'b1111, 1'b0);
        do_eval("R8 reserved", 2'd3, 4'b0000, 4'b0000, 1'b0);
        do_eval("R6 all empty again", 2'd1, 4'b0000, 4'b0000, 1'b1);
        do_idle(2'd3, 4'hF, 4'hF, 1'b1);
        do_eval("R3 back to back", 2'd0, 4'b0010, 4'b0010, 1'b1);
        do_eval("R8 back to back", 2'd3, 4'b1111, 4'b1111, 1'b0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            logic [3:0] k, f;
            logic oc;
            m = 2'($urandom_range(0, 3));
            k = 4'($urandom_range(0, 15));
            f = 4'($urandom_range(0, 15));
            oc = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) do_idle(m, k, f, oc);
            else case (m)
                2'd0: do_eval("R3 random any-set", m, k, f, oc);
                2'd1: do_eval("R5 random all-clear", m, k, f, oc);
                2'd2: do_eval("R7 random octal", m, k, f, oc);
                default: do_eval("R8 random reserved", m, k, f, oc);
            endcase
        end
        do_idle(2'd0, 4'd0, 4'd0, 1'b0);
        finish_run();
    end
endmodule